// File: doc/BRIEF.md
# Interrupt Priority Configuration Registers

This block is the per-CPU slice of an interrupt controller's CPU interface that holds the priority configuration state: one priority mask register, three binary point registers (group 0, secure group 1, non-secure group 1) and a read-only control word. The number of implemented physical priority bits is a build parameter. From it the block derives the preemption bit count, the write mask for the priority mask register and the smallest legal binary point for each group. It uses these values to filter software writes and to pick reset values.

Software reaches the registers through a plain register port: a select code, a write enable, write data and combinational read data. The effective priority and preemption bit counts and the three live binary point values go out on dedicated ports to the downstream priority logic. A compatibility parameter pins the priority width at 8 whatever the configured value is.

Top module: `prio_cfg_regs`

## Requirements
- R1: The effective priority bit count is the PRI_BITS_CFG parameter when it lies in 4..8, and 5 when PRI_BITS_CFG is 0. It appears on o_pri_bits.
- R2: With FORCE_EIGHT set to 1 the effective priority bit count is 8, whatever PRI_BITS_CFG holds.
- R3: The preemption bit count on o_pre_bits equals the priority bit count, except that 8 priority bits give 7 preemption bits.
- R4: A write to the priority mask (select 0) stores write data ANDed with 8'hFF shifted left by (8 - priority bits). The unimplemented low bits therefore read as zero.
- R5: A binary point write (select 1 = group 0, 2 = secure group 1, 3 = non-secure group 1) takes write data bits [2:0]. If that value is below the group's minimum, the minimum is stored instead. The minimum is (7 - preemption bits) for group 0 and secure group 1, and one more than that for non-secure group 1.
- R6: While reset is held, the priority mask reads 0 and each binary point reads its own group minimum.
- R7: The control word (select 4) reads (priority bits - 1) in bits [2:0], the value 1 in bits [6:4], 1 in bit 7 (affinity level 3 valid) and 0 in bit 3.
- R8: A write to select 4 or to an unused select code (5..7) changes no register. Reads of unused select codes return 0.
- R9: A write takes effect at the rising clock edge where the write enable is high. With the write enable low, no register changes.
- R10: Read data shows the selected register combinationally, and o_bp_g0, o_bp_g1s and o_bp_g1ns always carry the current binary point values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_sel | input | 3 | Register select code |
| i_we | input | 1 | Write enable |
| i_wdata | input | 8 | Write data |
| o_rdata | output | 8 | Read data of the selected register |
| o_pri_bits | output | 4 | Effective priority bit count |
| o_pre_bits | output | 4 | Effective preemption bit count |
| o_bp_g0 | output | 3 | Group 0 binary point |
| o_bp_g1s | output | 3 | Secure group 1 binary point |
| o_bp_g1ns | output | 3 | Non-secure group 1 binary point |

## Verification
The bench builds three copies that share one stimulus. The first is left unconfigured and so falls back to 5 bits. The second is set to the narrowest width, 4 bits. The third is configured to 6 bits with the force option on, which gives 8 priority bits and 7 preemption bits. With these three, the default fallback, the largest minimum binary point (4 for non-secure group 1), the full 8-bit mask with a zero floor, and the 8-to-7 preemption rule can all be reached with one set of writes. Each copy gets its own expected value for every read.

// File: rtl/prio_cfg_pkg.sv
package prio_cfg_pkg;

  localparam int DATA_W = 8;
  localparam int BP_W   = 3;
  localparam int CNT_W  = 4;
  localparam int SEL_W  = 3;
  localparam int N_GRP  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_MASK    = 3'd0,
    SEL_BP_G0   = 3'd1,
    SEL_BP_G1S  = 3'd2,
    SEL_BP_G1NS = 3'd3,
    SEL_CTRL    = 3'd4
  } reg_sel_e;

  function automatic int eff_pri_bits(input int cfg, input bit force8);
    if (force8)   return 8;
    if (cfg == 0) return 5;
    return cfg;
  endfunction

  function automatic int pre_of_pri(input int pri);
    return (pri == 8) ? 7 : pri;
  endfunction

  function automatic int min_bp_of(input int pre, input bit nonsecure);
    return 7 - pre + (nonsecure ? 1 : 0);
  endfunction

endpackage

// File: rtl/prio_rst_sync.sv
module prio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/prio_mask_reg.sv
module prio_mask_reg #(
  parameter int          DATA_W = 8,
  parameter logic [7:0]  KEEP   = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_en) q_d = wdata & KEEP[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_d;
  end

  // R4: unimplemented low bits never hold a one
  assert_mask_low_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~KEEP[DATA_W-1:0]) == '0);

  // R9: no write enable, no change
  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

  // R4 and R9: a write lands on the next edge, filtered
  assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == ($past(wdata) & KEEP[DATA_W-1:0]));
endmodule

// File: rtl/prio_bp_reg.sv
module prio_bp_reg #(
  parameter int BP_W = 3,
  parameter int MIN  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [BP_W-1:0] wdata,
  output logic [BP_W-1:0] q
);
  localparam logic [BP_W-1:0] FLOOR = BP_W'(MIN);

  logic [BP_W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_en) q_d = (wdata < FLOOR) ? FLOOR : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= FLOOR;
    else if (wr_en) q <= q_d;
  end

  // R5: value never below the group floor
  assert_bp_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q >= FLOOR);

  // R9: no write enable, no change
  assert_bp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

  // R5: an in-range write is stored unchanged
  assert_bp_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata >= FLOOR) |=> q == $past(wdata));
endmodule

// File: rtl/prio_ctrl_word.sv
module prio_ctrl_word #(
  parameter int PRI = 5
) (
  output logic [7:0] word
);
  localparam logic [2:0] PRI_FIELD = 3'(PRI - 1);
  localparam logic [2:0] ID_FIELD  = 3'd1;

  always_comb begin
    word      = '0;
    word[2:0] = PRI_FIELD;
    word[6:4] = ID_FIELD;
    word[7]   = 1'b1;
  end
endmodule

// File: rtl/prio_cfg_regs.sv
module prio_cfg_regs
  import prio_cfg_pkg::*;
#(
  parameter int PRI_BITS_CFG = 0,
  parameter bit FORCE_EIGHT  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] i_sel,
  input  logic             i_we,
  input  logic [DATA_W-1:0] i_wdata,
  output logic [DATA_W-1:0] o_rdata,
  output logic [CNT_W-1:0] o_pri_bits,
  output logic [CNT_W-1:0] o_pre_bits,
  output logic [BP_W-1:0]  o_bp_g0,
  output logic [BP_W-1:0]  o_bp_g1s,
  output logic [BP_W-1:0]  o_bp_g1ns
);
  localparam int PRI    = eff_pri_bits(PRI_BITS_CFG, FORCE_EIGHT);
  localparam int PRE    = pre_of_pri(PRI);
  localparam int MIN_S  = min_bp_of(PRE, 1'b0);
  localparam int MIN_NS = min_bp_of(PRE, 1'b1);
  localparam logic [7:0] KEEP = 8'(8'hFF << (8 - PRI));

  // R1: legal width window
  initial assert_pri_range_R1: assert (PRI >= 4 && PRI <= 8);

  logic rst_i_n;
  prio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  logic             we_mask;
  logic [N_GRP-1:0] we_bp;

  always_comb begin
    we_mask = i_we && (i_sel == SEL_MASK);
    we_bp   = '0;
    we_bp[0] = i_we && (i_sel == SEL_BP_G0);
    we_bp[1] = i_we && (i_sel == SEL_BP_G1S);
    we_bp[2] = i_we && (i_sel == SEL_BP_G1NS);
  end

  logic [DATA_W-1:0] mask_q;
  prio_mask_reg #(.DATA_W(DATA_W), .KEEP(KEEP)) u_mask (
    .clk(clk), .rst_n(rst_i_n), .wr_en(we_mask), .wdata(i_wdata), .q(mask_q)
  );

  logic [BP_W-1:0] bp_q [N_GRP];
  for (genvar g = 0; g < N_GRP; g++) begin : g_bp
    prio_bp_reg #(.BP_W(BP_W), .MIN((g == 2) ? MIN_NS : MIN_S)) u_bp (
      .clk(clk), .rst_n(rst_i_n), .wr_en(we_bp[g]),
      .wdata(i_wdata[BP_W-1:0]), .q(bp_q[g])
    );
  end

  logic [DATA_W-1:0] ctrl_word;
  prio_ctrl_word #(.PRI(PRI)) u_ctrl (.word(ctrl_word));

  always_comb begin
    o_rdata = '0;
    case (i_sel)
      SEL_MASK:    o_rdata = mask_q;
      SEL_BP_G0:   o_rdata = {{(DATA_W-BP_W){1'b0}}, bp_q[0]};
      SEL_BP_G1S:  o_rdata = {{(DATA_W-BP_W){1'b0}}, bp_q[1]};
      SEL_BP_G1NS: o_rdata = {{(DATA_W-BP_W){1'b0}}, bp_q[2]};
      SEL_CTRL:    o_rdata = ctrl_word;
      default:     o_rdata = '0;
    endcase
  end

  assign o_pri_bits = CNT_W'(PRI);
  assign o_pre_bits = CNT_W'(PRE);
  assign o_bp_g0    = bp_q[0];
  assign o_bp_g1s   = bp_q[1];
  assign o_bp_g1ns  = bp_q[2];

  // R5: non-secure group 1 floor sits one above the others
  assert_ns_above_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    o_bp_g1ns >= BP_W'(MIN_S + 1));

  // R8: writes to the control code or unused codes leave registers alone
  assert_ignored_sel_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (i_we && i_sel >= SEL_CTRL) |=> ($stable(mask_q) && $stable(o_bp_g0)
                                    && $stable(o_bp_g1s) && $stable(o_bp_g1ns)));
endmodule

// File: tb/sim_prio_cfg_regs.sv
module sim_prio_cfg_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] sel;
  logic       we;
  logic [7:0] wdata;

  logic [7:0] rd [3];
  logic [3:0] pri [3];
  logic [3:0] pre [3];
  logic [2:0] b0 [3];
  logic [2:0] b1 [3];
  logic [2:0] b2 [3];

  int n_run  = 0;
  int n_fail = 0;

  // expected geometry per copy, from the requirements
  int e_pri  [3] = '{5, 4, 8};
  int e_pre  [3] = '{5, 4, 7};
  int e_min  [3] = '{2, 3, 0};
  int e_mns  [3] = '{3, 4, 1};
  int e_keep [3] = '{8'hF8, 8'hF0, 8'hFF};

  always #5 clk = ~clk;

  prio_cfg_regs u0 (.clk(clk), .rst_n(rst_n), .i_sel(sel), .i_we(we), .i_wdata(wdata),
    .o_rdata(rd[0]), .o_pri_bits(pri[0]), .o_pre_bits(pre[0]),
    .o_bp_g0(b0[0]), .o_bp_g1s(b1[0]), .o_bp_g1ns(b2[0]));
  prio_cfg_regs #(.PRI_BITS_CFG(4)) u1 (.clk(clk), .rst_n(rst_n), .i_sel(sel), .i_we(we),
    .i_wdata(wdata), .o_rdata(rd[1]), .o_pri_bits(pri[1]), .o_pre_bits(pre[1]),
    .o_bp_g0(b0[1]), .o_bp_g1s(b1[1]), .o_bp_g1ns(b2[1]));
  prio_cfg_regs #(.PRI_BITS_CFG(6), .FORCE_EIGHT(1'b1)) u2 (.clk(clk), .rst_n(rst_n),
    .i_sel(sel), .i_we(we), .i_wdata(wdata), .o_rdata(rd[2]), .o_pri_bits(pri[2]),
    .o_pre_bits(pre[2]), .o_bp_g0(b0[2]), .o_bp_g1s(b1[2]), .o_bp_g1ns(b2[2]));

  task automatic chk(input string tag, input int idx, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s copy%0d actual=%0h expected=%0h", tag, idx, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] s, input int exp [3]);
    @(negedge clk); sel = s; #1;
    for (int i = 0; i < 3; i++) chk(tag, i, rd[i], exp[i]);
  endtask

  task automatic t_reset_state;
    int z [3] = '{0, 0, 0};
    rd_chk("R6 mask reset", 3'd0, z);
    rd_chk("R6 bp g0 reset", 3'd1, e_min);
    rd_chk("R6 bp g1s reset", 3'd2, e_min);
    rd_chk("R6 bp g1ns reset", 3'd3, e_mns);
    for (int i = 0; i < 3; i++) begin
      chk("R1 R2 pri bits", i, pri[i], e_pri[i]);
      chk("R3 pre bits", i, pre[i], e_pre[i]);
      chk("R10 bp port g1ns", i, b2[i], e_mns[i]);
    end
  endtask

  task automatic t_ctrl;
    int e [3];
    for (int i = 0; i < 3; i++) e[i] = (e_pri[i] - 1) | (1 << 4) | (1 << 7);
    rd_chk("R7 ctrl word", 3'd4, e);
  endtask

  task automatic t_mask;
    int e [3];
    wr(3'd0, 8'hFF);
    rd_chk("R4 mask all ones", 3'd0, e_keep);
    wr(3'd0, 8'hA5);
    for (int i = 0; i < 3; i++) e[i] = 8'hA5 & e_keep[i];
    rd_chk("R4 mask pattern", 3'd0, e);
    // R9 / R10: before the edge the old value stays visible
    @(negedge clk); sel = 3'd0; wdata = 8'h3C; we = 1'b1; #1;
    for (int i = 0; i < 3; i++) chk("R9 mask before edge", i, rd[i], e[i]);
    @(negedge clk); we = 1'b0; #1;
    for (int i = 0; i < 3; i++) chk("R9 R10 mask after edge", i, rd[i], 8'h3C & e_keep[i]);
  endtask

  task automatic t_bp;
    int e [3];
    int six [3] = '{6, 6, 6};
    for (int s = 1; s <= 3; s++) wr(3'(s), 8'h00);
    rd_chk("R5 clamp g0", 3'd1, e_min);
    rd_chk("R5 clamp g1s", 3'd2, e_min);
    rd_chk("R5 clamp g1ns", 3'd3, e_mns);
    for (int s = 1; s <= 3; s++) wr(3'(s), 8'h06);
    rd_chk("R5 store g0", 3'd1, six);
    rd_chk("R5 store g1ns", 3'd3, six);
    for (int i = 0; i < 3; i++) chk("R10 bp port g1s", i, b1[i], 6);
    wr(3'd1, 8'h0B);
    for (int i = 0; i < 3; i++) e[i] = (3 < e_min[i]) ? e_min[i] : 3;
    rd_chk("R5 low bits only g0", 3'd1, e);
    wr(3'd3, 8'h02);
    for (int i = 0; i < 3; i++) e[i] = (2 < e_mns[i]) ? e_mns[i] : 2;
    rd_chk("R5 ns floor", 3'd3, e);
    for (int i = 0; i < 3; i++) chk("R10 bp port g0", i, b0[i], (3 < e_min[i]) ? e_min[i] : 3);
  endtask

  task automatic t_ignored;
    int e [3];
    int z [3] = '{0, 0, 0};
    int six [3] = '{6, 6, 6};
    wr(3'd4, 8'h00);
    for (int i = 0; i < 3; i++) e[i] = (e_pri[i] - 1) | (1 << 4) | (1 << 7);
    rd_chk("R8 ctrl write ignored", 3'd4, e);
    wr(3'd6, 8'h00);
    rd_chk("R8 unused read zero", 3'd6, z);
    for (int i = 0; i < 3; i++) e[i] = 8'h3C & e_keep[i];
    rd_chk("R8 mask untouched", 3'd0, e);
    rd_chk("R8 bp g1s untouched", 3'd2, six);
    // R9: write enable low
    @(negedge clk); sel = 3'd0; wdata = 8'hFF; we = 1'b0;
    @(negedge clk); #1;
    for (int i = 0; i < 3; i++) chk("R9 no write without enable", i, rd[i], e[i]);
  endtask

  task automatic t_rerst;
    int z [3] = '{0, 0, 0};
    @(negedge clk); rst_n = 1'b0;
    rd_chk("R6 mask in reset", 3'd0, z);
    rd_chk("R6 bp g0 in reset", 3'd1, e_min);
    rd_chk("R6 bp g1ns in reset", 3'd3, e_mns);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; sel = '0; we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_ctrl();
    t_mask();
    t_bp();
    t_ignored();
    t_rerst();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule